// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Sequencer

This block is the master side of a wide asynchronous parallel memory port, such as a bank of flash devices sharing one 21-bit address bus and one 32-bit data bus. The bus has three active-low strobes: chip select, output enable and write enable. The block turns commands from a valid/ready request port into correctly ordered strobe, address and data-direction sequences. It drives per-line output-enable and pullup masks for both buses and returns read words on a streaming output with a valid strobe.

Three commands exist: a single write, a single read, and a burst read of N consecutive words. In a burst read, output enable stays low for the whole burst while the address climbs by one per word. Two programmable wait counts, in clock cycles, set the write-enable pulse width and the time an address is presented before the data is sampled. Chip select is held asserted the whole time. Between commands the bus rests with output enable and write enable both high and the data lines released with pullups on.

Top module: `flash_bus_seq`

## Requirements
- R1: While and after reset, the address lines are all driven (`bus_addr_oe` all ones) with value 0. The data lines are all inputs (`bus_data_oe` 0) with every pullup on. `we_n`=1, `oe_n`=1, `cs_n`=0, `ctl_oe`=3'b111, and `req_ready`=1.
- R2: `cs_n` is 0 in every cycle. Whenever `req_ready` is 1, `oe_n`=1, `we_n`=1 and no data line is driven.
- R3: A write (`req_op`=2'b00) accepted at an edge produces the following sequence. First, one cycle with the address and the data word driven and `we_n`=1. Then E cycles with `we_n`=0, where E is the effective write wait. Then one cycle with `we_n`=1 and the data still driven. Then a cycle with `done`=1.
- R4: `we_n` is low only while all 32 data lines are driven. During a write, `bus_data_o` carries the accepted word.
- R5: `oe_n` goes low only while no data line is driven and all data pullups are on. In every cycle the data pullup mask is the complement of the data direction mask.
- R6: A single read (`req_op`=2'b01) proceeds as follows. First comes one cycle with `oe_n`=1 and the data released. Then the address is presented with `oe_n`=0 for R cycles, where R is the effective read wait. Data is sampled at the end of the last of those cycles and appears on `rd_data` with `rd_valid`=1 in the following cycle.
- R7: A burst read (`req_op`=2'b10 or 2'b11) with count C ≥ 1 holds `oe_n` low for C×R consecutive cycles. Word k is presented at address (start+k) mod 2^21 for R cycles. Exactly C words are returned, in address order.
- R8: A burst with count 0 gives `done`=1 in the cycle after acceptance. There is no strobe activity, no `rd_valid`, and no change of address.
- R9: `req_ready` is 1 only when idle. A `req_valid` presented while busy is ignored and does not alter the running sequence.
- R10: `done` is a one-cycle pulse, followed by an idle cycle. For any read, the last word's `rd_valid` falls in the same cycle as `done`.
- R11: After a read, at least one cycle with `oe_n`=1 and no data driven passes before any data line is driven again.
- R12: A wait setting of 0 behaves exactly as a setting of 1. A setting of W ≥ 1 gives W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Sequencer idle, command accepted this cycle if valid |
| req_op | input | 2 | 00 write, 01 single read, 1x burst read |
| req_addr | input | 21 | Command address / burst start |
| req_wdata | input | 32 | Write word |
| req_count | input | 16 | Burst word count |
| cfg_we_wait | input | 8 | Write-enable low width in cycles (0 means 1) |
| cfg_rd_wait | input | 8 | Cycles per read address before sampling (0 means 1) |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 32 | Read word |
| bus_addr_o | output | 21 | Address lines |
| bus_addr_oe | output | 21 | Address direction mask, 1 = output |
| bus_addr_pu | output | 21 | Address pullup mask |
| bus_data_o | output | 32 | Data lines when driven |
| bus_data_oe | output | 32 | Data direction mask, 1 = output |
| bus_data_pu | output | 32 | Data pullup mask |
| bus_data_i | input | 32 | Data lines as seen from the pins |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| ctl_oe | output | 3 | Direction of the three strobes, 1 = output |

## Verification
Two events meet in the same cycle: the strobe for the final read word and the completion pulse. When the read wait is 1, word strobes also fall on back-to-back cycles. Bursts of random length are run with wait settings of 0 and 1 to provoke both cases. The bench predicts from the counts alone the cycle in which `done` rises and the cycle of every `rd_valid`, and compares each cycle. It also checks that the returned word count equals the requested count, so a strobe lost to the overlap would be caught.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WREL,
    ST_RTURN,
    ST_RLOW,
    ST_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_BURST = 2'b10,
    OP_BURSTX = 2'b11
  } seq_op_t;

endpackage

// File: rtl/pfb_wait_timer.sv
module pfb_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  // A zero setting is stretched to one cycle.
  function automatic logic [W-1:0] eff_wait(input logic [W-1:0] w);
    return (w == '0) ? ONE : w;
  endfunction

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= ONE;
    else if (load)       cnt <= eff_wait(len);
    else if (cnt > ONE)  cnt <= cnt - ONE;
  end

  assign last = (cnt == ONE);

  a_r12_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);
  a_r12_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt > ONE) |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/pfb_addr_gen.sv
module pfb_addr_gen #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] addr
);
  // Next burst address, wrapping at the top of the address space.
  function automatic logic [W-1:0] addr_step(input logic [W-1:0] a);
    return a + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= load_val;
    else if (step)  addr <= addr_step(addr);
  end

  a_r7_step_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr - $past(addr)) == W'(1));
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(addr));
endmodule

// File: rtl/pfb_read_capture.sv
module pfb_read_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] din,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= capture;
      if (capture) data <= din;
    end
  end

  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> valid && data == $past(din));
endmodule

// File: rtl/flash_bus_seq.sv
module flash_bus_seq
  import pfb_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [WAIT_W-1:0] cfg_we_wait,
  input  logic [WAIT_W-1:0] cfg_rd_wait,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [ADDR_W-1:0] bus_addr_oe,
  output logic [ADDR_W-1:0] bus_addr_pu,
  output logic [DATA_W-1:0] bus_data_o,
  output logic [DATA_W-1:0] bus_data_oe,
  output logic [DATA_W-1:0] bus_data_pu,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [2:0]        ctl_oe
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_state_t        state, state_nx;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] wdata_q;

  // Named internal events.
  logic accept, is_write, is_burst, is_zero;
  logic word_end, last_word, drive_data;
  logic t_load, t_last;
  logic [WAIT_W-1:0] t_len;
  logic a_load, a_step;
  logic [ADDR_W-1:0] a_val;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_write  = (seq_op_t'(req_op) == OP_WRITE);
  assign is_burst  = req_op[1];
  assign is_zero   = is_burst && (req_count == '0);

  assign word_end  = (state == ST_RLOW) && t_last;
  assign last_word = (remain == CNT_ONE);

  assign t_load = (state == ST_WSET) || (state == ST_RTURN) || (word_end && !last_word);
  assign t_len  = (state == ST_WSET) ? cfg_we_wait : cfg_rd_wait;

  assign a_load = (accept && is_write) || (state == ST_RTURN);
  assign a_val  = (state == ST_RTURN) ? cmd_addr : req_addr;
  assign a_step = word_end && !last_word;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept) state_nx = is_write ? ST_WSET : (is_zero ? ST_FIN : ST_RTURN);
      ST_WSET:  state_nx = ST_WLOW;
      ST_WLOW:  if (t_last) state_nx = ST_WREL;
      ST_WREL:  state_nx = ST_FIN;
      ST_RTURN: state_nx = ST_RLOW;
      ST_RLOW:  if (word_end && last_word) state_nx = ST_FIN;
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain   <= '0;
      cmd_addr <= '0;
      wdata_q  <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        cmd_addr <= req_addr;
        remain   <= is_burst ? req_count : CNT_ONE;
        if (is_write) wdata_q <= req_wdata;
      end else if (word_end) begin
        remain <= remain - CNT_ONE;
      end
    end
  end

  pfb_wait_timer #(.W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .last(t_last)
  );

  pfb_addr_gen #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(a_load), .load_val(a_val),
    .step(a_step), .addr(bus_addr_o)
  );

  pfb_read_capture #(.W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(word_end), .din(bus_data_i),
    .valid(rd_valid), .data(rd_data)
  );

  assign drive_data  = (state == ST_WSET) || (state == ST_WLOW) || (state == ST_WREL);
  assign bus_data_oe = {DATA_W{drive_data}};
  assign bus_data_pu = ~bus_data_oe;
  assign bus_data_o  = wdata_q;
  assign bus_addr_oe = '1;
  assign bus_addr_pu = '0;
  assign cs_n        = 1'b0;
  assign oe_n        = (state != ST_RLOW);
  assign we_n        = (state != ST_WLOW);
  assign ctl_oe      = 3'b111;
  assign done        = (state == ST_FIN);

  a_r4_we_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (&bus_data_oe));
  a_r5_oe_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (bus_data_oe == '0) && (&bus_data_pu));
  a_r2_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> oe_n && we_n && (bus_data_oe == '0));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);
  a_r11_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_data_oe[0]) |-> $past(oe_n));
  a_r8_zero_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_zero) |=> done && oe_n && !rd_valid);
  a_r7_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && !last_word) |=> !oe_n);
endmodule

// File: tb/tb_flash_bus_seq.sv
`timescale 1ns/1ps
module tb_flash_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'b00;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [15:0] req_count = '0;
  logic [7:0] cfg_we_wait = 8'd1, cfg_rd_wait = 8'd1;
  logic done, rd_valid;
  logic [31:0] rd_data;
  logic [20:0] bus_addr_o, bus_addr_oe, bus_addr_pu;
  logic [31:0] bus_data_o, bus_data_oe, bus_data_pu, bus_data_i;
  logic cs_n, oe_n, we_n;
  logic [2:0] ctl_oe;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  flash_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
    .cfg_we_wait(cfg_we_wait), .cfg_rd_wait(cfg_rd_wait), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_addr_o(bus_addr_o),
    .bus_addr_oe(bus_addr_oe), .bus_addr_pu(bus_addr_pu), .bus_data_o(bus_data_o),
    .bus_data_oe(bus_data_oe), .bus_data_pu(bus_data_pu), .bus_data_i(bus_data_i),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .ctl_oe(ctl_oe)
  );

  // Memory model seen on the pins: a fixed scramble of the address.
  function automatic logic [31:0] mem_word(input logic [20:0] a);
    return {a[10:0], a} ^ 32'hA5C3_0F96;
  endfunction
  assign bus_data_i = mem_word(bus_addr_o);

  function automatic int eff(input logic [7:0] w);
    return (w == 8'd0) ? 1 : int'(w);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [20:0] a, input logic [31:0] wd,
                         input logic [15:0] cnt, input logic [7:0] ww, input logic [7:0] rw,
                         input bit noise);
    int n_we, n_rd, words, total, widx;
    logic [20:0] prev_addr, ea;
    string tw, tr;
    n_we = eff(ww);
    n_rd = eff(rw);
    tw = (ww == 8'd0) ? "R12" : "R3";
    tr = (rw == 8'd0) ? "R12" : "R6";
    words = (op == 2'b01) ? 1 : int'(cnt);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    prev_addr = bus_addr_o;
    cfg_we_wait = ww; cfg_rd_wait = rw;
    req_op = op; req_addr = a; req_wdata = wd; req_count = cnt; req_valid = 1'b1;
    @(negedge clk);
    if (noise) begin
      req_op = ~op; req_addr = ~a; req_wdata = ~wd; req_count = cnt + 16'd3;
    end else req_valid = 1'b0;
    if (op == 2'b00) total = n_we + 3;
    else if (words == 0) total = 1;
    else total = 2 + words * n_rd;
    widx = 0;
    for (int cyc = 1; cyc <= total; cyc++) begin
      if (cyc == total) req_valid = 1'b0;
      chk(cs_n == 1'b0, "R2", cs_n, 0);
      chk(req_ready == 1'b0, "R9", req_ready, 0);
      chk(done == (cyc == total), "R10", done, cyc == total);
      if (op == 2'b00) begin
        chk(bus_addr_o == a, "R3", bus_addr_o, a);
        chk(we_n == !(cyc >= 2 && cyc <= n_we + 1), tw, we_n, !(cyc >= 2 && cyc <= n_we + 1));
        chk(bus_data_oe == ((cyc < total) ? 32'hFFFF_FFFF : 32'h0), "R4", bus_data_oe, cyc < total);
        if (cyc < total) chk(bus_data_o == wd, "R4", bus_data_o, wd);
        chk(oe_n == 1'b1, "R3", oe_n, 1);
        chk(rd_valid == 1'b0, "R3", rd_valid, 0);
      end else begin
        chk(bus_data_oe == 32'h0, "R5", bus_data_oe, 0);
        chk(bus_data_pu == 32'hFFFF_FFFF, "R5", bus_data_pu, 32'hFFFF_FFFF);
        chk(we_n == 1'b1, "R5", we_n, 1);
        if (words == 0) begin
          chk(oe_n == 1'b1, "R8", oe_n, 1);
          chk(bus_addr_o == prev_addr, "R8", bus_addr_o, prev_addr);
          chk(rd_valid == 1'b0, "R8", rd_valid, 0);
        end else begin
          chk(oe_n == !(cyc >= 2 && cyc < total), "R7", oe_n, !(cyc >= 2 && cyc < total));
          if (cyc >= 2 && cyc < total) begin
            ea = 21'(a + 21'((cyc - 2) / n_rd));
            chk(bus_addr_o == ea, "R7", bus_addr_o, ea);
          end
          chk(rd_valid == (cyc > 2 && ((cyc - 2) % n_rd) == 0), tr, rd_valid,
              (cyc > 2 && ((cyc - 2) % n_rd) == 0));
          if (cyc > 2 && ((cyc - 2) % n_rd) == 0) begin
            ea = 21'(a + 21'(widx));
            chk(rd_data == mem_word(ea), tr, rd_data, mem_word(ea));
            widx++;
          end
          if (cyc == total) chk(oe_n && bus_data_oe == 0 && rd_valid, "R11", {oe_n, rd_valid}, 2'b11);
        end
      end
      @(negedge clk);
    end
    chk(req_ready == 1'b1, "R9", req_ready, 1);
    chk(done == 1'b0, "R10", done, 0);
    if (op != 2'b00) chk(widx == words, "R7", widx, words);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R1: outputs during and after reset.
    chk(bus_addr_o == 0 && bus_addr_oe == 21'h1FFFFF, "R1", bus_addr_oe, 21'h1FFFFF);
    chk(bus_data_oe == 0 && bus_data_pu == 32'hFFFF_FFFF, "R1", bus_data_pu, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_addr_o == 0, "R1", bus_addr_o, 0);
    chk(bus_addr_oe == 21'h1FFFFF, "R1", bus_addr_oe, 21'h1FFFFF);
    chk(bus_data_oe == 0, "R1", bus_data_oe, 0);
    chk(bus_data_pu == 32'hFFFF_FFFF, "R1", bus_data_pu, 32'hFFFF_FFFF);
    chk({cs_n, oe_n, we_n} == 3'b011, "R1", {cs_n, oe_n, we_n}, 3'b011);
    chk(ctl_oe == 3'b111, "R1", ctl_oe, 3'b111);
    chk(req_ready == 1'b1 && done == 1'b0, "R1", req_ready, 1);

    // Directed corners.
    run_cmd(2'b00, 21'h12345, 32'hDEAD_BEEF, 16'd0, 8'd2, 8'd1, 1'b0);
    run_cmd(2'b01, 21'h00ABC, 32'h0, 16'd9, 8'd1, 8'd3, 1'b0);
    run_cmd(2'b00, 21'h00001, 32'h1234_5678, 16'd0, 8'd1, 8'd1, 1'b0);
    run_cmd(2'b10, 21'h00100, 32'h0, 16'd5, 8'd1, 8'd1, 1'b0);
    run_cmd(2'b10, 21'h0F0F0, 32'h0, 16'd0, 8'd1, 8'd1, 1'b1);
    run_cmd(2'b11, 21'h1FFFFE, 32'h0, 16'd4, 8'd1, 8'd2, 1'b1);
    run_cmd(2'b00, 21'h0AAAA, 32'hCAFE_F00D, 16'd0, 8'd0, 8'd0, 1'b1);
    run_cmd(2'b10, 21'h15555, 32'h0, 16'd3, 8'd0, 8'd0, 1'b0);
    run_cmd(2'b00, 21'h00042, 32'h0BAD_F00D, 16'd0, 8'd3, 8'd0, 1'b0);

    // Random mix.
    for (int i = 0; i < 80; i++) begin
      logic [1:0] op;
      int pick;
      pick = int'($urandom % 3);
      op = (pick == 0) ? 2'b00 : (pick == 1) ? 2'b01 : 2'b10;
      run_cmd(op, 21'($urandom), $urandom,
              (($urandom % 8) == 0) ? 16'd0 : 16'(1 + $urandom % 6),
              8'($urandom % 5), 8'($urandom % 5), bit'($urandom % 2));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule